// File: doc/BRIEF.md
# Glitch-free PWM Channel Core

This block drives one pulse-width-modulated pin from three 16-bit settings: a prescale count, a period count and a high count. A prescaler divides the input clock, and each of its ticks advances a period counter. The pin is high at the start of every period, for as many ticks as the high count asks, and low for the rest.

Settings written through the update strobe go into a pending copy. The running copy takes the pending values only when a period ends, so a period already in progress always finishes with the values it started with. Clearing the enable also waits for the end of the current period. After that the pin stays low and the counters rest at zero.

A one-cycle period-start pulse marks the first cycle of every period. It can pace software or a neighbouring channel. All pins are plain control and status levels. Nothing here carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_channel_core`

## Requirements
- R1: With running prescale value P and period value D, every period lasts (P+1)*(D+1) clock cycles. The prescaler counts 0..P and ticks on its last count. The period counter steps on each tick and wraps after D.
- R2: The pin is high for min(H, D+1)*(P+1) cycles at the start of each period and low for the rest. H=0 gives a pin that stays low. H>D gives a pin that stays high for the whole period.
- R3: A one-cycle pulse on cfg_update copies cfg_prescale, cfg_period and cfg_high into the pending copy. The running copy changes only at a period boundary, so the period in progress ends with the old values.
- R4: An update never stops or gaps the output. While enabled, each period is followed at once by the next one, with no idle cycle between them.
- R5: When cfg_enable is low at the end of a period, the channel stops at that boundary. The period in progress completes unchanged. Afterwards pwm_out stays low and period_start stays low.
- R6: If cfg_enable is high while the channel is idle, the next clock edge starts a period from the pending values with both counters at zero. period_start is high in that first cycle.
- R7: period_start is high for exactly one cycle, the first cycle of every period, and the running copy is loaded in that same cycle.
- R8: After reset pwm_out and period_start are low. The pending copy holds prescale 0, period 1 and high 0, so enabling without an update gives 2-cycle periods with the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | 16 | Prescale value P |
| cfg_period | input | 16 | Period value D |
| cfg_high | input | 16 | High count H, in prescaler ticks |
| cfg_update | input | 1 | Strobe that copies the three values into the pending copy |
| cfg_enable | input | 1 | Run level, sampled at period boundaries |
| pwm_out | output | 1 | Registered PWM pin, active high |
| period_start | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
The embedded properties check, on every cycle, the things that hold everywhere:
- both counters stay within their running limits;
- period_start coincides with zeroed counters;
- the running copy holds still inside a period;
- an idle channel keeps the pin low;
- an enabled wrap is followed at once by a new period;
- a high count above the period count keeps the pin high.

Only the bench's scenarios can show the arithmetic and the ordering. These are the exact period and high-time lengths across a sweep of small settings, the one-period delay between an update and its effect, the full final period before a stop, and the reset defaults.

// File: rtl/pwm_core_pkg.sv
package pwm_core_pkg;
  localparam int unsigned PWM_W = 16;
  typedef logic [PWM_W-1:0] pwm_word_t;
  localparam pwm_word_t WORD_ONE  = pwm_word_t'(1);
  localparam pwm_word_t WORD_ZERO = '0;

  typedef struct packed {
    pwm_word_t prescale;
    pwm_word_t period;
    pwm_word_t high;
  } pwm_cfg_t;

  localparam pwm_cfg_t CFG_RESET = '{prescale: WORD_ZERO, period: WORD_ONE, high: WORD_ZERO};
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_core_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd,
  input  pwm_cfg_t cfg_in,
  input  logic     load,
  output pwm_cfg_t act,
  output pwm_cfg_t act_nxt
);
  pwm_cfg_t pend_q, act_q;

  always_comb act_nxt = load ? pend_q : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= CFG_RESET;
      act_q  <= CFG_RESET;
    end else begin
      if (upd) pend_q <= cfg_in;
      act_q <= act_nxt;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_core_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      clear,
  input  pwm_word_t limit,
  output pwm_word_t cnt,
  output logic      tick
);
  pwm_word_t cnt_q;

  always_comb tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= WORD_ZERO;
    else if (clear|tick) cnt_q <= WORD_ZERO;
    else if (run)        cnt_q <= cnt_q + WORD_ONE;
  end

  assign cnt = cnt_q;

  // The prescale count never runs past its running limit.
  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_core_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      tick,
  input  pwm_word_t limit,
  output pwm_word_t cnt,
  output pwm_word_t cnt_nxt,
  output logic      wrap
);
  pwm_word_t cnt_q;

  always_comb begin
    wrap = tick && (cnt_q == limit);
    if (clear)     cnt_nxt = WORD_ZERO;
    else if (tick) cnt_nxt = cnt_q + WORD_ONE;
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= WORD_ZERO;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;

  // The period count never exceeds its running limit while ticks arrive.
  assert_div_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt_q <= limit));
endmodule

// File: rtl/pwm_channel_core.sv
module pwm_channel_core
  import pwm_core_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PWM_W-1:0]      cfg_prescale,
  input  logic [PWM_W-1:0]      cfg_period,
  input  logic [PWM_W-1:0]      cfg_high,
  input  logic                  cfg_update,
  input  logic                  cfg_enable,
  output logic                  pwm_out,
  output logic                  period_start
);
  pwm_cfg_t  cfg_in, act, act_nxt;
  pwm_word_t pre_cnt, per_cnt, per_nxt;
  logic      running_q, tick, wrap, boundary, start_now, run_nxt, out_d;
  logic      out_q, start_q;

  always_comb begin
    cfg_in.prescale = cfg_prescale;
    cfg_in.period   = cfg_period;
    cfg_in.high     = cfg_high;
  end

  // An idle channel sits permanently on a boundary.
  always_comb begin
    boundary  = !running_q || wrap;
    start_now = boundary && cfg_enable;
    run_nxt   = boundary ? cfg_enable : running_q;
    out_d     = run_nxt && (per_nxt < act_nxt.high);
  end

  pwm_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .upd(cfg_update), .cfg_in(cfg_in),
    .load(start_now), .act(act), .act_nxt(act_nxt)
  );

  pwm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(running_q), .clear(boundary),
    .limit(act.prescale), .cnt(pre_cnt), .tick(tick)
  );

  pwm_period_ctr u_per (
    .clk(clk), .rst_n(rst_n), .clear(boundary), .tick(tick),
    .limit(act.period), .cnt(per_cnt), .cnt_nxt(per_nxt), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      out_q     <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      running_q <= run_nxt;
      out_q     <= out_d;
      start_q   <= start_now;
    end
  end

  assign pwm_out      = out_q;
  assign period_start = start_q;

  // A period begins with both counters at zero.
  assert_start_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> (running_q && pre_cnt == WORD_ZERO && per_cnt == WORD_ZERO));
  // A period is never cut short.
  assert_no_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !wrap) |=> (running_q && !period_start));
  // Running settings hold still inside a period.
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !period_start) |-> $stable(act));
  // An enabled wrap is followed at once by the next period.
  assert_gap_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && cfg_enable) |=> period_start);
  // A stopped channel keeps the pin low.
  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> !pwm_out);
  // A high count beyond the period count holds the pin high.
  assert_full_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && act.high > act.period) |-> pwm_out);
endmodule

// File: tb/tb_pwm_channel_core.sv
`timescale 1ns/1ps
module tb_pwm_channel_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_prescale = '0, cfg_period = '0, cfg_high = '0;
  logic cfg_update = 1'b0, cfg_enable = 1'b0;
  logic pwm_out, period_start;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_channel_core dut (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_period(cfg_period),
    .cfg_high(cfg_high), .cfg_update(cfg_update), .cfg_enable(cfg_enable),
    .pwm_out(pwm_out), .period_start(period_start)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge where period_start is high; counts that period.
  task automatic measure(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      if (pwm_out) hi++;
      len++;
      @(negedge clk);
      cfg_update = 1'b0;
    end while (!period_start && len < 2000);
  endtask

  task automatic sync_start();
    int n = 0;
    while (!period_start && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) check("R4 sync", 0, 1);
  endtask

  task automatic set_cfg(input int p, input int d, input int h);
    cfg_prescale = 16'(p); cfg_period = 16'(d); cfg_high = 16'(h);
    cfg_update = 1'b1;
  endtask

  function automatic int exp_hi(input int p, input int d, input int h);
    return ((h < d + 1) ? h : d + 1) * (p + 1);
  endfunction

  initial begin
    int len, hi, op, od, oh;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 pwm_out at reset", int'(pwm_out), 0);
    check("R8 period_start at reset", int'(period_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 no pulse while idle", int'(period_start), 0);
    // R6: enable on idle starts a period on the next edge
    cfg_enable = 1'b1;
    @(negedge clk);
    check("R6 period_start after enable", int'(period_start), 1);
    measure(len, hi);
    check("R8 default period length", len, 2);
    check("R8 default high time", hi, 0);
    check("R7 pulse recurs", int'(period_start), 1);
    @(negedge clk);
    check("R7 pulse lasts one cycle", int'(period_start), 0);
    sync_start();
    op = 0; od = 1; oh = 0;
    // R1/R2/R3/R4 sweep: update at a period start, old period then new ones
    for (int p = 0; p < 3; p++)
      for (int d = 0; d < 4; d++)
        for (int h = 0; h < 6; h++) begin
          set_cfg(p, d, h);
          measure(len, hi);
          check("R3 current period keeps old length", len, (op + 1) * (od + 1));
          check("R3 current period keeps old high", hi, exp_hi(op, od, oh));
          measure(len, hi);
          if ((op + 1) * (od + 1) > 1) begin
            check("R1 new period length", len, (p + 1) * (d + 1));
            check("R2 new high time", hi, exp_hi(p, d, h));
          end
          measure(len, hi);
          check("R4 following period length", len, (p + 1) * (d + 1));
          check("R2 following high time", hi, exp_hi(p, d, h));
          op = p; od = d; oh = h;
        end
    // R5: disable mid-flight at a full-duty setting finishes the period
    set_cfg(1, 3, 9);
    measure(len, hi);
    measure(len, hi);
    cfg_enable = 1'b0;
    measure(len, hi);
    check("R5 final period high cycles", hi, 8);
    begin
      int hs = 0, ps = 0;
      for (int i = 0; i < 20; i++) begin
        if (pwm_out) hs++;
        if (period_start) ps++;
        @(negedge clk);
      end
      check("R5 pin low after stop", hs, 0);
      check("R5 no pulse after stop", ps, 0);
    end
    // R6: update while idle, then enable uses the pending values
    set_cfg(2, 1, 1);
    @(negedge clk); cfg_update = 1'b0;
    cfg_enable = 1'b1;
    @(negedge clk);
    check("R6 start after re-enable", int'(period_start), 1);
    check("R6 pin high at first cycle", int'(pwm_out), 1);
    measure(len, hi);
    check("R6 period from pending values", len, 6);
    check("R6 high from pending values", hi, 3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule